// File: doc/BRIEF.md
# Interference-Aware Read Reference Selector

This block supplies the three read reference codes that separate the four threshold-voltage states of a two-bit cell when a wordline is sensed. A read request carries a wordline index, a set of default reference codes and two status bits that say whether the wordline above or below the target has been programmed since the target itself was written. When neither neighbour has been programmed, the default codes go out untouched. When at least one has, each code is raised by a learned shift that belongs to its own state boundary. The sum clamps at the top code value. Programming a neighbour can only push a victim cell's threshold upward, so the shifts are unsigned and never lower a reference.

The shifts are refreshed by a background scheduler. It counts program/erase cycle ticks. Every `PE_INTERVAL` ticks it raises a learning request toward an external measurement engine, and that request gives way to regular traffic. The engine returns one mean shift per boundary with a done strobe. Those values are then used until the next refresh.

The scheduler has three states:
- **IDLE**: counting ticks, no refresh owed.
- **PEND**: a refresh is owed but the request is held off.
- **LEARN**: the request is asserted.

Its transitions are:
- IDLE to PEND on the tick that completes an interval.
- PEND to LEARN when no read and no I/O activity is present.
- LEARN to PEND when a read or I/O activity preempts the request.
- PEND or LEARN to IDLE on the done strobe.

Top module: `vref_select`

## Requirements
- R1: After reset `ref_valid` and `learn_req` are low and every stored shift is zero, so a read with a neighbour flagged returns the default codes.
- R2: A read request sampled at a clock edge gives `ref_valid` high for exactly the next cycle. In that cycle `ref_wl` echoes the index, and with both neighbour flags low `ref_code` equals `dflt_code`.
- R3: With `nbr_up` or `nbr_dn` (or both) high, each boundary code is its default plus that boundary's own stored shift.
- R4: A shifted code that would exceed 2^CODE_W-1 is clamped to 2^CODE_W-1. No output code is ever below its default.
- R5: After the `PE_INTERVAL`-th `pe_tick` since reset or since the previous refresh, `learn_req` rises within two cycles when no read and no I/O activity is present.
- R6: While `learn_req` is high, a cycle with `io_busy` or `rd_req` high makes `learn_req` low on the next cycle. The request comes back once both are low.
- R7: `learn_done` while a refresh is owed (PEND or LEARN) loads `learn_shift` into the stored shifts and drops `learn_req` on the next cycle. `learn_done` in IDLE leaves the shifts unchanged.
- R8: A read sampled in the same cycle as an accepted `learn_done` uses the shifts held before the load.
- R9: Fewer than `PE_INTERVAL` ticks never raise `learn_req`.
- R10: Boundary i occupies bits [i*CODE_W +: CODE_W] of the code buses and [i*SHIFT_W +: SHIFT_W] of `learn_shift`. Boundary 0 is erased/P1, 1 is P1/P2 and 2 is P2/P3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request strobe |
| rd_wl | input | WL_W | Wordline index of the read |
| nbr_up | input | 1 | Wordline above programmed since target write |
| nbr_dn | input | 1 | Wordline below programmed since target write |
| dflt_code | input | NB*CODE_W | Default reference codes, one per boundary |
| ref_valid | output | 1 | Reference codes valid (one cycle per read) |
| ref_wl | output | WL_W | Wordline index belonging to `ref_code` |
| ref_code | output | NB*CODE_W | Selected reference codes |
| pe_tick | input | 1 | One program/erase cycle completed |
| io_busy | input | 1 | Regular I/O activity present; preempts learning |
| learn_req | output | 1 | Request for a learning pass |
| learn_done | input | 1 | Learning pass finished, shifts valid |
| learn_shift | input | NB*SHIFT_W | Measured mean shifts, one per boundary |

## Verification
The read path and the refresh path meet in two ways. In the first, a read arrives in the same cycle as the done strobe that loads new shifts. The bench issues both together while `learn_req` is high. It checks that this read carries the old shifts, that `learn_req` falls, and that the next read carries the new shifts. In the second, a read or `io_busy` lands while the request is asserted. That must withdraw the request one cycle later, and the request must come back once the path is quiet. Both are driven directly and judged at the ports.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
    typedef enum logic [1:0] {
        SCH_IDLE  = 2'd0,
        SCH_PEND  = 2'd1,
        SCH_LEARN = 2'd2
    } sched_state_t;
endpackage

// File: rtl/vrs_pe_sched.sv
module vrs_pe_sched
    import vrs_pkg::*;
#(
    parameter int PE_INTERVAL = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pe_tick,
    input  logic hold,
    input  logic learn_done,
    output logic learn_req,
    output logic load_shift
);
    localparam int CNT_W = (PE_INTERVAL > 2) ? $clog2(PE_INTERVAL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PE_INTERVAL - 1);

    logic [CNT_W-1:0] tick_cnt;
    logic             expire;
    sched_state_t     state, state_nx;

    assign expire = pe_tick && (tick_cnt == CNT_LAST);

    // P/E tick counter, free-running across intervals
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tick_cnt <= '0;
        else if (pe_tick)
            tick_cnt <= expire ? '0 : tick_cnt + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SCH_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SCH_IDLE: begin
                if (expire) state_nx = SCH_PEND;
            end
            SCH_PEND: begin
                if (learn_done)  state_nx = SCH_IDLE;
                else if (!hold)  state_nx = SCH_LEARN;
            end
            SCH_LEARN: begin
                if (learn_done)  state_nx = SCH_IDLE;
                else if (hold)   state_nx = SCH_PEND;
            end
            default: state_nx = SCH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        learn_req  = 1'b0;
        load_shift = 1'b0;
        unique case (state)
            SCH_IDLE:  ;
            SCH_PEND:  load_shift = learn_done;
            SCH_LEARN: begin
                learn_req  = 1'b1;
                load_shift = learn_done;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vrs_shift_bank.sv
module vrs_shift_bank #(
    parameter int NB      = 3,
    parameter int SHIFT_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [NB*SHIFT_W-1:0] din,
    output logic [NB*SHIFT_W-1:0] q
);
    for (genvar i = 0; i < NB; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[i*SHIFT_W +: SHIFT_W] <= '0;
            else if (load)
                q[i*SHIFT_W +: SHIFT_W] <= din[i*SHIFT_W +: SHIFT_W];
        end
    end
endmodule

// File: rtl/vrs_ref_adder.sv
module vrs_ref_adder #(
    parameter int CODE_W  = 8,
    parameter int SHIFT_W = 6
) (
    input  logic               en,
    input  logic [CODE_W-1:0]  base,
    input  logic [SHIFT_W-1:0] shift,
    output logic [CODE_W-1:0]  code
);
    logic [CODE_W:0] sum;

    always_comb begin
        sum = {1'b0, base} + (en ? (CODE_W+1)'(shift) : '0);
        code = sum[CODE_W] ? '1 : sum[CODE_W-1:0];
    end
endmodule

// File: rtl/vref_select.sv
module vref_select
    import vrs_pkg::*;
#(
    parameter int NB          = 3,
    parameter int CODE_W      = 8,
    parameter int SHIFT_W     = 6,
    parameter int WL_W        = 7,
    parameter int PE_INTERVAL = 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_req,
    input  logic [WL_W-1:0]       rd_wl,
    input  logic                  nbr_up,
    input  logic                  nbr_dn,
    input  logic [NB*CODE_W-1:0]  dflt_code,
    output logic                  ref_valid,
    output logic [WL_W-1:0]       ref_wl,
    output logic [NB*CODE_W-1:0]  ref_code,
    input  logic                  pe_tick,
    input  logic                  io_busy,
    output logic                  learn_req,
    input  logic                  learn_done,
    input  logic [NB*SHIFT_W-1:0] learn_shift
);
    logic                  load_shift;
    logic                  shift_en;
    logic [NB*SHIFT_W-1:0] shift_q;
    logic [NB*CODE_W-1:0]  code_nx;

    vrs_pe_sched #(.PE_INTERVAL(PE_INTERVAL)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .pe_tick    (pe_tick),
        .hold       (io_busy | rd_req),
        .learn_done (learn_done),
        .learn_req  (learn_req),
        .load_shift (load_shift)
    );

    vrs_shift_bank #(.NB(NB), .SHIFT_W(SHIFT_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_shift),
        .din   (learn_shift),
        .q     (shift_q)
    );

    assign shift_en = nbr_up | nbr_dn;

    for (genvar i = 0; i < NB; i++) begin : g_bnd
        vrs_ref_adder #(.CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) u_add (
            .en    (shift_en),
            .base  (dflt_code[i*CODE_W +: CODE_W]),
            .shift (shift_q[i*SHIFT_W +: SHIFT_W]),
            .code  (code_nx[i*CODE_W +: CODE_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_valid <= 1'b0;
            ref_wl    <= '0;
            ref_code  <= '0;
        end else begin
            ref_valid <= rd_req;
            if (rd_req) begin
                ref_wl   <= rd_wl;
                ref_code <= code_nx;
            end
        end
    end
endmodule

// File: rtl/vref_select_chk.sv
module vref_select_chk #(
    parameter int NB     = 3,
    parameter int CODE_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_req,
    input logic                 nbr_up,
    input logic                 nbr_dn,
    input logic [NB*CODE_W-1:0] dflt_code,
    input logic                 ref_valid,
    input logic [NB*CODE_W-1:0] ref_code,
    input logic                 io_busy,
    input logic                 learn_req,
    input logic                 learn_done
);
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> ref_valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !ref_valid);

    a_r2_default_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !nbr_up && !nbr_dn) |=> (ref_code == $past(dflt_code)));

    for (genvar i = 0; i < NB; i++) begin : g_bnd
        a_r4_not_below_default: assert property (@(posedge clk) disable iff (!rst_n)
            rd_req |=> (ref_code[i*CODE_W +: CODE_W] >= $past(dflt_code[i*CODE_W +: CODE_W])));
    end

    a_r6_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (learn_req && (io_busy || rd_req)) |=> !learn_req);

    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (learn_req && learn_done) |=> !learn_req);
endmodule

bind vref_select vref_select_chk #(.NB(NB), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .nbr_up     (nbr_up),
    .nbr_dn     (nbr_dn),
    .dflt_code  (dflt_code),
    .ref_valid  (ref_valid),
    .ref_code   (ref_code),
    .io_busy    (io_busy),
    .learn_req  (learn_req),
    .learn_done (learn_done)
);

// File: tb/vref_select_bench.sv
module vref_select_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 3, CODE_W = 8, SHIFT_W = 6, WL_W = 7, INTERVAL = 10;
    localparam int NVEC = 7;
    // {nbr_up, nbr_dn, wl[6:0], d2, d1, d0}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 7'd3,   8'd200, 8'd120, 8'd40},
        {1'b1, 1'b0, 7'd5,   8'd150, 8'd100, 8'd40},
        {1'b0, 1'b1, 7'd9,   8'd150, 8'd100, 8'd40},
        {1'b1, 1'b1, 7'd127, 8'd192, 8'd240, 8'd0},
        {1'b1, 1'b0, 7'd64,  8'd193, 8'd235, 8'd250},
        {1'b0, 1'b0, 7'd1,   8'd255, 8'd255, 8'd255},
        {1'b1, 1'b1, 7'd0,   8'd0,   8'd0,   8'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_req = 0, nbr_up = 0, nbr_dn = 0, pe_tick = 0, io_busy = 0, learn_done = 0;
    logic [WL_W-1:0] rd_wl = '0, ref_wl;
    logic [NB*CODE_W-1:0] dflt_code = '0, ref_code;
    logic [NB*SHIFT_W-1:0] learn_shift = '0;
    logic ref_valid, learn_req;
    int n_chk = 0, n_fail = 0;
    int sh [NB] = '{0, 0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    vref_select #(.NB(NB), .CODE_W(CODE_W), .SHIFT_W(SHIFT_W), .WL_W(WL_W),
                  .PE_INTERVAL(INTERVAL)) u_vref_select (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_wl(rd_wl),
        .nbr_up(nbr_up), .nbr_dn(nbr_dn), .dflt_code(dflt_code),
        .ref_valid(ref_valid), .ref_wl(ref_wl), .ref_code(ref_code),
        .pe_tick(pe_tick), .io_busy(io_busy), .learn_req(learn_req),
        .learn_done(learn_done), .learn_shift(learn_shift)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NB*CODE_W-1:0] expect_code(input logic en, input logic [NB*CODE_W-1:0] d);
        logic [NB*CODE_W-1:0] r;
        for (int i = 0; i < NB; i++) begin
            int s;
            s = int'(d[i*CODE_W +: CODE_W]) + (en ? sh[i] : 0);
            r[i*CODE_W +: CODE_W] = (s > 255) ? 8'd255 : s[7:0];
        end
        return r;
    endfunction

    // issue one read; returns after the valid cycle has been sampled
    task automatic do_read(input logic up, input logic dn, input logic [WL_W-1:0] wl,
                           input logic [NB*CODE_W-1:0] d, input string tag);
        @(negedge clk);
        rd_req = 1; nbr_up = up; nbr_dn = dn; rd_wl = wl; dflt_code = d;
        @(negedge clk);
        rd_req = 0; nbr_up = 0; nbr_dn = 0;
        chk({tag, " valid"}, {63'd0, ref_valid}, 64'd1);
        chk({tag, " code/wl"}, {33'd0, ref_wl, ref_code}, {33'd0, wl, expect_code(up | dn, d)});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pe_tick = 1;
            @(negedge clk); pe_tick = 0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ref_valid", {63'd0, ref_valid}, 64'd0);
        chk("R1 reset learn_req", {63'd0, learn_req}, 64'd0);
        rst_n = 1;
        // R1: shifts are zero after reset, so flagged read returns defaults
        do_read(1, 1, 7'd12, {8'd90, 8'd60, 8'd30}, "R1 zero shift");

        // R9: one tick short of the interval
        ticks(INTERVAL - 1);
        repeat (3) @(negedge clk);
        chk("R9 no early request", {63'd0, learn_req}, 64'd0);
        // R5: interval complete
        ticks(1);
        repeat (2) @(negedge clk);
        chk("R5 request raised", {63'd0, learn_req}, 64'd1);

        // R6: preemption by io_busy
        io_busy = 1;
        @(negedge clk);
        chk("R6 withdrawn on busy", {63'd0, learn_req}, 64'd0);
        @(negedge clk);
        chk("R6 held while busy", {63'd0, learn_req}, 64'd0);
        io_busy = 0;
        @(negedge clk);
        chk("R6 restored", {63'd0, learn_req}, 64'd1);

        // R8 + R7: done and read in the same cycle
        learn_done = 1;
        learn_shift = {6'd63, 6'd20, 6'd5};
        rd_req = 1; nbr_up = 1; rd_wl = 7'd44; dflt_code = {8'd10, 8'd10, 8'd10};
        @(negedge clk);
        learn_done = 0; rd_req = 0; nbr_up = 0;
        chk("R8 old shift used", {40'd0, ref_code}, {40'd0, 8'd10, 8'd10, 8'd10});
        chk("R7 request dropped", {63'd0, learn_req}, 64'd0);
        sh = '{5, 20, 63};

        // R2/R3/R4/R10: vector table
        for (int v = 0; v < NVEC; v++) begin
            do_read(VEC[v][32], VEC[v][31], VEC[v][30:24], VEC[v][23:0],
                    $sformatf("R2/R3/R4/R10 vec%0d", v));
        end

        // R7: done while idle is ignored
        @(negedge clk);
        learn_done = 1; learn_shift = {6'd1, 6'd1, 6'd1};
        @(negedge clk);
        learn_done = 0;
        chk("R7 idle no request", {63'd0, learn_req}, 64'd0);
        do_read(1, 0, 7'd77, {8'd0, 8'd0, 8'd0}, "R7 idle done ignored");

        // R4: saturation corner
        do_read(0, 1, 7'd2, {8'd255, 8'd236, 8'd251}, "R4 saturate");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule